// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

The block runs a 16-bit counter that advances on every system clock and watches one external capture pin. The pin goes through a two-stage synchroniser and then an edge detector. Each rising edge copies the current count into a rising-edge register, and each falling edge copies it into a falling-edge register. Every capture raises an interrupt request, which stays high until it is cleared.

Software reads the two registers and takes differences. A falling capture minus the rising capture before it gives the pulse width. Two rising captures subtracted give the period. Each register has a new-data flag and an overrun flag, so a reader can tell whether the value is fresh and whether one was lost. An overflow flag records every wrap of the counter, so a reader can extend intervals longer than 65536 clocks.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset:
  - every readable location returns 0;
  - `irq` is low.
- R2: The counter advances by one on every clock and wraps from 0xFFFF to 0. Address 3 returns its live value.
- R3: A wrap sets the overflow flag, which is status bit 4. A status read (address 2) returns the flag and then clears it. A wrap in the same cycle as the read leaves the flag set.
- R4: A rising edge on `cap_in` stores the count into the rising register (address 0) within 4 clocks of the edge. The difference between two captures equals the number of clocks between the two edges.
- R5: A falling edge on `cap_in` stores the count into the falling register (address 1) within 4 clocks of the edge. The same difference rule as R4 applies.
- R6: Each register has a new-data flag, set by its capture: rising is status bit 0 and falling is status bit 1.
  - Reading the register clears its flag.
  - If a capture lands in the same cycle as that read, the read returns the old value and the flag stays set.
- R7: A capture into a register whose new-data flag is still set raises that register's overrun flag: rising is status bit 2 and falling is status bit 3. A status read clears both overrun flags and leaves the new-data flags as they are.
- R8: `irq` rises within 4 clocks of any capture edge and stays high until `irq_clr`. A capture in the same cycle as `irq_clr` keeps `irq` high.
- R9: Edges are captured correctly when the input is high for 4 clocks and low for 4 clocks, which gives a period of 8 clocks.
- R10: `rd_data` is registered.
  - It shows the addressed value one clock after `rd_en`.
  - It holds while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture input |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 rising capture, 1 falling capture, 2 status, 3 live count |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Capture interrupt request |
| irq_clr | input | 1 | Clears the interrupt request |

## Verification
Two pairs of events can meet in the same clock edge: a capture and an interrupt clear, and a capture and a software read of that same capture register.

The bench counts the synchroniser delay and raises `irq_clr` or `rd_en` for exactly the edge on which the capture lands. It then judges by the ports:
- `irq` must stay high after the clear;
- the read must return the previous capture;
- a following status read must still show the new-data flag with no overrun.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_RISE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FALL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd3;
  localparam int NUM_CH = 2;
  localparam int CH_RISE = 0;
  localparam int CH_FALL = 1;
  localparam int STAT_W = 5;
  typedef struct packed {
    logic ovf;
    logic fall_ovr;
    logic rise_ovr;
    logic fall_new;
    logic rise_new;
  } stat_t;
endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
  assign fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  // the counter is at its top value, so the next edge takes it to zero
  assign wrap = &count;
endmodule

// File: rtl/ect_capture_chan.sv
module ect_capture_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_ev,
  input  logic [W-1:0] count,
  input  logic         take,
  input  logic         ovr_clr,
  output logic [W-1:0] data,
  output logic         fresh,
  output logic         ovr
);
  always_ff @(posedge clk) begin
    if (rst)         data <= '0;
    else if (cap_ev) data <= count;
  end

  // a capture beats a read in the same cycle
  always_ff @(posedge clk) begin
    if (rst)         fresh <= 1'b0;
    else if (cap_ev) fresh <= 1'b1;
    else if (take)   fresh <= 1'b0;
  end

  // a value is lost only when the old one is still unread
  always_ff @(posedge clk) begin
    if (rst)                           ovr <= 1'b0;
    else if (cap_ev && fresh && !take) ovr <= 1'b1;
    else if (ovr_clr)                  ovr <= 1'b0;
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  input  logic              irq_clr
);
  logic [CNT_W-1:0]  count;
  logic              cnt_wrap;
  logic              rise_ev;
  logic              fall_ev;
  logic [NUM_CH-1:0] ev;
  logic [NUM_CH-1:0] take;
  logic [NUM_CH-1:0] fresh_q;
  logic [NUM_CH-1:0] ovr_q;
  logic [CNT_W-1:0]  cap_q [NUM_CH];
  logic              st_rd;
  logic              ovf_q;
  stat_t             stat;

  ect_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cap_in),
    .rise (rise_ev),
    .fall (fall_ev)
  );

  ect_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .wrap  (cnt_wrap)
  );

  assign ev[CH_RISE] = rise_ev;
  assign ev[CH_FALL] = fall_ev;
  assign st_rd = rd_en && (rd_addr == ADDR_STAT);

  always_comb begin
    take[CH_RISE] = rd_en && (rd_addr == ADDR_RISE);
    take[CH_FALL] = rd_en && (rd_addr == ADDR_FALL);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ect_capture_chan #(.W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .cap_ev  (ev[ch]),
      .count   (count),
      .take    (take[ch]),
      .ovr_clr (st_rd),
      .data    (cap_q[ch]),
      .fresh   (fresh_q[ch]),
      .ovr     (ovr_q[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           ovf_q <= 1'b0;
    else if (cnt_wrap) ovf_q <= 1'b1;
    else if (st_rd)    ovf_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (|ev)     irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  always_comb begin
    stat.ovf      = ovf_q;
    stat.fall_ovr = ovr_q[CH_FALL];
    stat.rise_ovr = ovr_q[CH_RISE];
    stat.fall_new = fresh_q[CH_FALL];
    stat.rise_new = fresh_q[CH_RISE];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        ADDR_RISE: rd_data <= cap_q[CH_RISE];
        ADDR_FALL: rd_data <= cap_q[CH_FALL];
        ADDR_STAT: rd_data <= CNT_W'(stat);
        default:   rd_data <= count;
      endcase
    end
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             irq_clr,
  input logic             rise_ev,
  input logic             fall_ev,
  input logic             rise_fresh,
  input logic             fall_fresh,
  input logic             wrap,
  input logic             ovf,
  input logic [CNT_W-1:0] count
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == CNT_W'($past(count) + 1'b1)));

  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf);

  assert_rise_capture_R4: assert property (@(posedge clk) disable iff (rst)
    rise_ev |=> rise_fresh);

  assert_fall_capture_R5: assert property (@(posedge clk) disable iff (rst)
    fall_ev |=> fall_fresh);

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (rise_ev || fall_ev) |=> irq);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !rise_ev && !fall_ev) |=> !irq);

  assert_one_edge_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_ev, fall_ev}));
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .irq_clr    (irq_clr),
  .rise_ev    (rise_ev),
  .fall_ev    (fall_ev),
  .rise_fresh (fresh_q[0]),
  .fall_fresh (fresh_q[1]),
  .wrap       (cnt_wrap),
  .ovf        (ovf_q),
  .count      (count)
);

// File: tb/tb_edge_capture_timer.sv
module tb_edge_capture_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap_in = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_addr = 2'd0;
  logic [W-1:0] rd_data;
  logic         irq;
  logic         irq_clr = 1'b0;

  int checks = 0;
  int failures = 0;

  edge_capture_timer dut (
    .clk     (clk),
    .rst     (rst),
    .cap_in  (cap_in),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq),
    .irq_clr (irq_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] span(input logic [W-1:0] a, input logic [W-1:0] b);
    return b - a;
  endfunction

  function automatic logic [W-1:0] stat_word(input bit rn, input bit fn, input bit ro,
                                             input bit fo, input bit ov);
    return {11'd0, ov, fo, ro, fn, rn};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_en = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, r, f, f_prev, r_prev;
    int h, l, h_prev, l_prev;
    void'($urandom(32'd1234));
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(2'd0, a); check("R1 rise reg", a, 16'd0);
    rd(2'd1, a); check("R1 fall reg", a, 16'd0);
    rd(2'd2, a); check("R1 status", a, 16'd0);

    // R2 live count and R10 read latency/hold
    rd(2'd3, a);
    tick(9);
    rd(2'd3, b);
    check("R2 count step", span(a, b), 16'd10);
    tick(3);
    check("R10 hold", rd_data, b);

    // R4/R8 latency and width
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    cap_in = 1'b1;
    tick(2);
    check("R8 not early", {15'd0, irq}, 16'd0);
    tick(1);
    check("R8 irq within 4", {15'd0, irq}, 16'd1);
    tick(7);
    cap_in = 1'b0;
    tick(4);
    rd(2'd0, r); rd(2'd1, f);
    check("R5 width 10", span(r, f), 16'd10);
    f_prev = f;

    // R8 capture and clear in the same cycle
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    check("R8 clear", {15'd0, irq}, 16'd0);
    cap_in = 1'b1;
    tick(2);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    check("R8 capture beats clear", {15'd0, irq}, 16'd1);

    // R6 read of falling register in the capture cycle
    tick(5);
    cap_in = 1'b0;
    tick(2);
    rd(2'd1, a);
    check("R6 collision old value", a, f_prev);
    rd(2'd2, a);
    check("R6 flags kept", a, stat_word(1, 1, 0, 0, 0));
    rd(2'd0, r); rd(2'd1, f);
    check("R4 width 8", span(r, f), 16'd8);
    rd(2'd2, a);
    check("R6 flags cleared", a, stat_word(0, 0, 0, 0, 0));

    // R7 overrun on both registers
    cap_in = 1'b1; tick(6); cap_in = 1'b0; tick(6);
    cap_in = 1'b1; tick(6); cap_in = 1'b0; tick(6);
    rd(2'd2, a);
    check("R7 overrun set", a, stat_word(1, 1, 1, 1, 0));
    rd(2'd2, a);
    check("R7 overrun cleared", a, stat_word(1, 1, 0, 0, 0));
    rd(2'd0, r); rd(2'd1, f);
    check("R7 latest width", span(r, f), 16'd6);

    // R9 minimum high and low times
    cap_in = 1'b1; tick(4); cap_in = 1'b0; tick(4); cap_in = 1'b1;
    tick(6);
    rd(2'd2, a);
    check("R9 status", a, stat_word(1, 1, 1, 0, 0));
    rd(2'd0, r); rd(2'd1, f);
    check("R9 low time 4", span(f, r), 16'd4);
    tick(1);
    cap_in = 1'b0;
    tick(4);
    rd(2'd1, f);
    check("R9 high time 10", span(r, f), 16'd10);
    rd(2'd2, a);

    // random pulses: width and period
    h_prev = 0; l_prev = 0; r_prev = '0;
    for (int i = 0; i < 30; i++) begin
      h = 4 + int'($urandom % 37);
      l = 6 + int'($urandom % 35);
      cap_in = 1'b1; tick(h); cap_in = 1'b0; tick(4);
      rd(2'd0, r); rd(2'd1, f);
      check("R5 random width", span(r, f), 16'(h));
      if (i > 0) check("R4 random period", span(r_prev, r), 16'(h_prev + l_prev));
      tick(l - 6);
      r_prev = r; h_prev = h; l_prev = l;
    end
    rd(2'd2, a);

    // R3 overflow
    tick(65540);
    rd(2'd2, a);
    check("R3 overflow set", a & 16'h0010, 16'h0010);
    rd(2'd2, a);
    check("R3 overflow cleared", a & 16'h0010, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule